// File: doc/BRIEF.md
# Dual-Phase Interleaved Phase Accumulator

This block produces a square wave whose frequency is set by a 16-bit increment word, at up to twice the rate a single phase accumulator can reach from the same clock. It keeps two accumulators in parallel. One starts at zero and the other starts one increment ahead. Both advance by twice the increment on every rising edge. The output takes the most significant bit of the first accumulator while the clock is low, and the most significant bit of the second while the clock is high. Seen one half-cycle at a time, the result matches a single accumulator that steps by the increment on every half-cycle.

The increment word is not followed continuously. It is captured only while the load strobe is high. That capture resets both accumulators together, so a dirty or changing increment source never disturbs a running waveform. The output comes from two flops and an XOR gate. At each clock edge exactly one of the two flops can change, so the phase switch cannot produce a runt pulse.

Top module: `dual_phase_nco`

## Requirements
- R1: While `rst_n` is low, `wave_out` is 0 and both accumulators and the captured increment are cleared.
- R2: On a rising edge with `load` high, the captured increment N takes the value of `incr`, accumulator A is set to 0 and accumulator B is set to N, all in the same edge.
- R3: On a rising edge with `load` low, both accumulators advance by the same amount: 2N modulo 2^16 (N shifted left one bit, top bit dropped, 0 in the low bit).
- R4: Accumulator B always exceeds accumulator A by exactly the captured N, modulo 2^16.
- R5: A change of `incr` while `load` is low has no effect on the output sequence.
- R6: While `load` is held high, the accumulators stay at their initial values, so the output alternates between bit 15 of 0 (low phase) and bit 15 of N (high phase).
- R7: During a low clock phase `wave_out` equals bit 15 of accumulator A. During a high clock phase it equals bit 15 of the value accumulator B held before that phase's rising edge.
- R8: Number the half-phases after the release of `load` k = 0, 1, 2, …, with k = 0 being the first low phase. Then `wave_out` in half-phase k equals bit 15 of (k·N mod 2^16).
- R9: A load during a running sequence restarts the sequence at k = 0 with the new N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both levels are used as output phases |
| rst_n | input | 1 | Asynchronous active-low reset |
| incr | input | 16 | Increment word N, captured on load |
| load | input | 1 | Capture strobe; restarts both accumulators |
| wave_out | output | 1 | Interleaved square-wave output |

## Verification
A load and an accumulation step can fall on the same rising edge whenever `load` is raised mid-run. The bench raises it after long runs at a different N, and also holds it high across several edges. The rule under test is that the load wins: the half-phase sequence must restart exactly at k = 0 with the new N, with no leftover advance from the old N. The bench judges this by comparing every half-phase, sampled in the middle of the phase, with bit 15 of k·N mod 2^16, which it computes arithmetically for a sweep of increment values that includes 0, 1, 0x8000 and 0xFFFF.

// File: rtl/dual_phase_nco.sv
`timescale 1ns/1ps
module dual_phase_nco #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] incr,
  input  logic             load,
  output logic             wave_out
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] step, acc_a, acc_b;
  logic [WIDTH-1:0] step2;
  logic             pos_q, neg_q;

  assign step2 = {step[MSB-1:0], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step  <= '0;
      acc_a <= '0;
      acc_b <= '0;
    end else if (load) begin
      step  <= incr;
      acc_a <= '0;
      acc_b <= incr;
    end else begin
      acc_a <= acc_a + step2;
      acc_b <= acc_b + step2;
    end
  end

  // Only one of these flops toggles per edge, so the XOR cannot glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= 1'b0;
    else        pos_q <= acc_b[MSB] ^ neg_q;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= acc_a[MSB] ^ pos_q;
  end

  assign wave_out = pos_q ^ neg_q;

  // R2
  load_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc_a == '0 && acc_b == $past(incr) && step == $past(incr)));

  // R3
  same_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (WIDTH'(acc_b - $past(acc_b)) == WIDTH'(acc_a - $past(acc_a))));

  // R4
  phase_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    WIDTH'(acc_b - acc_a) == step);

  // R5
  incr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(step));

  // R7
  low_phase_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wave_out == acc_a[MSB]);
endmodule

// File: tb/dual_phase_nco_tb.sv
`timescale 1ns/1ps
module dual_phase_nco_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] incr = '0;
  logic        load = 1'b0;
  logic        wave_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  dual_phase_nco #(.WIDTH(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .incr(incr), .load(load), .wave_out(wave_out)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: wave_out=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit ref_bit(input longint k, input logic [15:0] n);
    return 1'(((k * longint'(n)) & 64'hFFFF) >> 15);
  endfunction

  // Raise load after a falling edge, hold for 'hold' rising edges, release.
  task automatic do_load(input logic [15:0] n, input int hold);
    @(negedge clk); #1;
    incr = n; load = 1'b1;
    repeat (hold) @(posedge clk);
    #1 load = 1'b0;
  endtask

  // Half-phase k even = low phase (after falling edge), odd = high phase.
  task automatic run_seq(input logic [15:0] n, input int start, input int count, input string req);
    for (int k = start; k < start + count; k++) begin
      if (k % 2 == 0) @(negedge clk); else @(posedge clk);
      #2;
      check(wave_out, ref_bit(k, n), req);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] sweep [8];
    sweep = '{16'h0001, 16'h0000, 16'h8000, 16'hFFFF, 16'h4000, 16'h1234, 16'h00FF, 16'hA5C3};

    // R1: reset state, clock running
    repeat (3) begin
      @(negedge clk); #2; check(wave_out, 1'b0, "R1");
      @(posedge clk); #2; check(wave_out, 1'b0, "R1");
    end
    @(negedge clk); #1 rst_n = 1'b1;

    // R8 / R2 / R3 / R7: sweep of increment values
    foreach (sweep[i]) begin
      do_load(sweep[i], 1);
      run_seq(sweep[i], 0, 300, "R8");
    end

    // R5: change incr without load; sequence continues with old N
    do_load(16'h0ABC, 1);
    run_seq(16'h0ABC, 0, 40, "R8");
    incr = 16'h7001;
    run_seq(16'h0ABC, 40, 80, "R5");

    // R6: load held high for several edges
    @(negedge clk); #1;
    incr = 16'hC001; load = 1'b1;
    @(posedge clk); #1;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk); #2; check(wave_out, 1'b0, "R6");
      @(posedge clk); #2; check(wave_out, 1'b1, "R6");
    end
    #1 load = 1'b0;
    run_seq(16'hC001, 0, 100, "R6");

    // R9: reload mid-run with a new N restarts at k = 0
    do_load(16'h3333, 1);
    run_seq(16'h3333, 0, 50, "R9");
    do_load(16'h0F0F, 1);
    run_seq(16'h0F0F, 0, 200, "R9");

    // R1: reset in the middle of a run
    @(negedge clk); #1 rst_n = 1'b0;
    #2 check(wave_out, 1'b0, "R1");
    @(posedge clk); #2 check(wave_out, 1'b0, "R1");
    @(negedge clk); #1 rst_n = 1'b1;
    do_load(16'h2001, 1);
    run_seq(16'h2001, 0, 60, "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule